// File: doc/BRIEF.md
# Byte-Wide Instruction Prefetch Queue

This block is the prefetch half of a bus interface for a processor whose external data path is one byte wide. It keeps a small first-in first-out store of opcode bytes, four deep by default, and launches one single-byte opcode fetch cycle as soon as one slot is free and the bus is free. It does not wait for room for a whole word. The execution side consumes the oldest byte from the head of the store. It may also ask for a data operand access, which runs ahead of any prefetch that has not yet started. A 16-bit operand is carried as two byte cycles, low byte then high byte, back to back.

The bus is handled one cycle at a time. When the block starts a cycle it raises a one-clock start strobe: `fetch_req_o` for an opcode byte or `opnd_start_o` for an operand byte. The surrounding bus logic ends the cycle with a one-clock `bus_ack_i`. For an opcode fetch, `bus_data_i` carries the byte in that same clock. A taken branch pulses `flush_i` with the new target address. The flush empties the store and reloads the fetch pointer. If an opcode fetch is already on the bus, it is allowed to finish, but its byte is thrown away.

Top module: `bytefetch_unit`

## Requirements
- R1: After reset the queue is empty (`count_o` = 0, `head_valid_o` = 0), `fetch_addr_o` equals `RESET_ADDR` (20'hFFFF0 by default) and no fetch is requested while `bus_idle_i` is low.
- R2: At most one bus cycle is outstanding. `fetch_req_o` is never raised while an earlier opcode fetch has not yet been acknowledged.
- R3: An opcode fetch is requested only while fewer than DEPTH bytes are held. Once the queue is full, popping a single byte is enough to raise `fetch_req_o` in the following clock. A push is never accepted into a full queue.
- R4: Acknowledged opcode bytes leave through `head_data_o` in the order they arrived.
- R5: `fetch_addr_o` rises by exactly one for each opcode byte accepted into the queue.
- R6: While `opnd_req_i` is high, no opcode fetch is started. With the bus idle, the operand cycle is started instead.
- R7: An opcode fetch already on the bus completes before an operand cycle starts.
- R8: With `opnd_wide_i` = 1, an operand access is two byte cycles. The first has `opnd_hi_o` = 0. The second has `opnd_hi_o` = 1 and starts in the clock right after the first acknowledge, even if `bus_idle_i` is low. `opnd_done_o` pulses once, on the second acknowledge.
- R9: `flush_i` empties the queue by the next clock and loads `flush_addr_i` into `fetch_addr_o`. A byte acknowledged for a fetch that was in flight at the flush (or in the flush clock itself) is discarded and does not advance the address.
- R10: A pop and an accepted push in the same clock leave `count_o` unchanged.
- R11: A pop while the queue is empty is ignored: the count stays 0 and later bytes still arrive in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_idle_i | input | 1 | External bus free to start a new cycle |
| bus_ack_i | input | 1 | One-clock end of the current bus cycle |
| bus_data_i | input | DW | Opcode byte, valid with `bus_ack_i` on a fetch cycle |
| pop_i | input | 1 | Consume the head byte |
| opnd_req_i | input | 1 | Operand access pending; held until `opnd_done_o` |
| opnd_wide_i | input | 1 | Pending operand is 16 bits (two byte cycles) |
| flush_i | input | 1 | Taken branch: empty queue, reload fetch pointer |
| flush_addr_i | input | AW | New fetch address for a flush |
| head_data_o | output | DW | Oldest queued byte |
| head_valid_o | output | 1 | Queue holds at least one byte |
| fetch_req_o | output | 1 | Start strobe of an opcode byte fetch |
| fetch_addr_o | output | AW | Address of the next opcode byte |
| count_o | output | $clog2(DEPTH+1) | Bytes held in the queue |
| opnd_start_o | output | 1 | Start strobe of an operand byte cycle |
| opnd_hi_o | output | 1 | Current operand cycle moves the high byte |
| opnd_done_o | output | 1 | Last operand byte cycle acknowledged |

## Verification
The main function is first driven with a free bus and a continuous fetch stream until the queue fills. This separates the stop at four bytes from the restart after one pop. The stream is then mixed with narrow operands, wide operands and an operand raised while a fetch is still waiting for its acknowledge, which tells apart priority at launch from pre-emption of a running cycle. Flushes are applied once with a fetch in flight and once with the bus quiet, so a discarded stale byte can be told apart from a normal reload. A pop is timed to fall exactly on an acknowledge, and another is issued on an empty queue, to expose errors in the count.

// File: rtl/bfq_pkg.sv
`timescale 1ns/100ps
package bfq_pkg;
  // Bus ownership of the prefetch interface
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_FETCH = 2'd1,
    BUS_OPND  = 2'd2
  } bus_state_e;
endpackage

// File: rtl/bfq_fifo.sv
`timescale 1ns/100ps
module bfq_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [DW-1:0]                push_data_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                head_data_o,
  output logic                         head_valid_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok, empty;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty && !flush_i;

  // next state
  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = bump(wr_q);
      if (pop_ok)  rd_d = bump(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // byte storage, one enable per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push_ok && (wr_q == PW'(g));
    always_ff @(posedge clk_i) begin
      if (slot_we) mem_q[g] <= push_data_i;
    end
  end

  assign head_data_o  = mem_q[rd_q];
  assign head_valid_o = !empty;
  assign count_o      = cnt_q;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_empty_pop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i && !flush_i) |=> (count_o == '0));
  assert_pushpop_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty && !full_o && !flush_i) |=> $stable(count_o));
endmodule

// File: rtl/bfq_arb.sv
`timescale 1ns/100ps
module bfq_arb
  import bfq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_idle_i,
  input  logic bus_ack_i,
  input  logic opnd_req_i,
  input  logic opnd_wide_i,
  input  logic flush_i,
  input  logic room_i,
  output logic fetch_req_o,
  output logic fetch_ack_o,
  output logic opnd_start_o,
  output logic opnd_hi_o,
  output logic opnd_done_o
);
  bus_state_e st_q, st_d;
  logic wide_q, wide_d;
  logic hi_q, hi_d;
  logic drop_q, drop_d;
  logic again_q, again_d;

  // next state and strobes
  always_comb begin
    st_d         = st_q;
    wide_d       = wide_q;
    hi_d         = hi_q;
    drop_d       = drop_q;
    again_d      = 1'b0;
    fetch_req_o  = 1'b0;
    fetch_ack_o  = 1'b0;
    opnd_start_o = again_q;
    opnd_done_o  = 1'b0;
    case (st_q)
      BUS_IDLE: begin
        if (bus_idle_i) begin
          if (opnd_req_i) begin
            st_d         = BUS_OPND;
            opnd_start_o = 1'b1;
            wide_d       = opnd_wide_i;
            hi_d         = 1'b0;
          end else if (room_i && !flush_i) begin
            st_d        = BUS_FETCH;
            fetch_req_o = 1'b1;
            drop_d      = 1'b0;
          end
        end
      end
      BUS_FETCH: begin
        if (bus_ack_i) begin
          st_d        = BUS_IDLE;
          fetch_ack_o = !drop_q && !flush_i;
          drop_d      = 1'b0;
        end else if (flush_i) begin
          drop_d = 1'b1;
        end
      end
      BUS_OPND: begin
        if (bus_ack_i) begin
          if (wide_q && !hi_q) begin
            hi_d    = 1'b1;
            again_d = 1'b1;
          end else begin
            st_d        = BUS_IDLE;
            opnd_done_o = 1'b1;
            hi_d        = 1'b0;
            wide_d      = 1'b0;
          end
        end
      end
      default: st_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BUS_IDLE;
      wide_q  <= 1'b0;
      hi_q    <= 1'b0;
      drop_q  <= 1'b0;
      again_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      wide_q  <= wide_d;
      hi_q    <= hi_d;
      drop_q  <= drop_d;
      again_q <= again_d;
    end
  end

  assign opnd_hi_o = hi_q && (st_q == BUS_OPND);

  assert_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |=> (!fetch_req_o && !opnd_start_o));
  assert_opnd_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_req_i |-> !fetch_req_o);
  assert_fetch_runs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BUS_FETCH && !bus_ack_i) |=> !opnd_start_o);
  assert_wide_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BUS_OPND && bus_ack_i && wide_q && !hi_q) |=> (opnd_start_o && opnd_hi_o));
  assert_stale_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BUS_FETCH && flush_i && !bus_ack_i) |=> !fetch_ack_o);
endmodule

// File: rtl/bfq_addr.sv
`timescale 1ns/100ps
module bfq_addr #(
  parameter int            AW         = 20,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = load_i || step_i;
    addr_d  = load_i ? load_addr_i : addr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= RESET_ADDR;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (addr_o == $past(addr_o) + 1'b1));
  assert_addr_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == $past(load_addr_i)));
endmodule

// File: rtl/bytefetch_unit.sv
`timescale 1ns/100ps
module bytefetch_unit #(
  parameter int            DEPTH      = 4,
  parameter int            DW         = 8,
  parameter int            AW         = 20,
  parameter logic [AW-1:0] RESET_ADDR = {AW{1'b1}} << 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_idle_i,
  input  logic                       bus_ack_i,
  input  logic [DW-1:0]              bus_data_i,
  input  logic                       pop_i,
  input  logic                       opnd_req_i,
  input  logic                       opnd_wide_i,
  input  logic                       flush_i,
  input  logic [AW-1:0]              flush_addr_i,
  output logic [DW-1:0]              head_data_o,
  output logic                       head_valid_o,
  output logic                       fetch_req_o,
  output logic [AW-1:0]              fetch_addr_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       opnd_start_o,
  output logic                       opnd_hi_o,
  output logic                       opnd_done_o
);
  logic q_full;
  logic byte_take;

  bfq_arb u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_idle_i   (bus_idle_i),
    .bus_ack_i    (bus_ack_i),
    .opnd_req_i   (opnd_req_i),
    .opnd_wide_i  (opnd_wide_i),
    .flush_i      (flush_i),
    .room_i       (!q_full),
    .fetch_req_o  (fetch_req_o),
    .fetch_ack_o  (byte_take),
    .opnd_start_o (opnd_start_o),
    .opnd_hi_o    (opnd_hi_o),
    .opnd_done_o  (opnd_done_o)
  );

  bfq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .push_i       (byte_take),
    .push_data_i  (bus_data_i),
    .pop_i        (pop_i),
    .head_data_o  (head_data_o),
    .head_valid_o (head_valid_o),
    .count_o      (count_o),
    .full_o       (q_full)
  );

  bfq_addr #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (flush_i),
    .load_addr_i (flush_addr_i),
    .step_i      (byte_take),
    .addr_o      (fetch_addr_o)
  );

  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0 && !head_valid_o));
endmodule

// File: tb/bytefetch_unit_tb_top.sv
`timescale 1ns/100ps
module bytefetch_unit_tb_top;
  localparam logic [19:0] RST_A = 20'hFFFF0;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_idle_i = 1'b0;
  logic        bus_ack_i = 1'b0;
  logic [7:0]  bus_data_i = 8'h00;
  logic        pop_i = 1'b0;
  logic        opnd_req_i = 1'b0;
  logic        opnd_wide_i = 1'b0;
  logic        flush_i = 1'b0;
  logic [19:0] flush_addr_i = 20'h0;
  logic [7:0]  head_data_o;
  logic        head_valid_o;
  logic        fetch_req_o;
  logic [19:0] fetch_addr_o;
  logic [2:0]  count_o;
  logic        opnd_start_o;
  logic        opnd_hi_o;
  logic        opnd_done_o;

  always #2 clk = ~clk;

  bytefetch_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_idle_i(bus_idle_i), .bus_ack_i(bus_ack_i),
    .bus_data_i(bus_data_i), .pop_i(pop_i), .opnd_req_i(opnd_req_i),
    .opnd_wide_i(opnd_wide_i), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .head_data_o(head_data_o), .head_valid_o(head_valid_o), .fetch_req_o(fetch_req_o),
    .fetch_addr_o(fetch_addr_o), .count_o(count_o), .opnd_start_o(opnd_start_o),
    .opnd_hi_o(opnd_hi_o), .opnd_done_o(opnd_done_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  int ev_q[$];
  bit pend = 0, pend_fetch = 0, drop = 0;
  logic [19:0] pend_addr = '0;
  int wcnt = 0, lat = 1, cyc = 0;
  int dup = 0, prio_bad = 0, full_bad = 0, overlap = 0, done_cnt = 0;
  int lo_ack_cyc = -10, hi_start_cyc = -20;

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) cyc++;

  // bus responder / driver side of the scoreboard
  always @(negedge clk) begin
    #1;
    if (fetch_req_o && pend) dup++;
    if (opnd_start_o && pend && pend_fetch) overlap++;
    if (fetch_req_o && opnd_req_i) prio_bad++;
    if (fetch_req_o && count_o == 3'd4) full_bad++;
    bus_ack_i = 1'b0;
    if (pend) begin
      if (wcnt == 0) begin
        bus_ack_i = 1'b1;
        if (pend_fetch) begin
          bus_data_i = pat(pend_addr);
          if (!drop) exp_q.push_back(pat(pend_addr));
        end else begin
          bus_data_i = 8'h00;
          if (!opnd_hi_o) lo_ack_cyc = cyc;
        end
        pend = 0;
      end else wcnt--;
    end else if (fetch_req_o) begin
      pend = 1; pend_fetch = 1; pend_addr = fetch_addr_o; drop = 0; wcnt = lat;
      ev_q.push_back(0);
    end else if (opnd_start_o) begin
      pend = 1; pend_fetch = 0; wcnt = lat;
      ev_q.push_back(opnd_hi_o ? 2 : 1);
      if (opnd_hi_o) hi_start_cyc = cyc;
    end
  end

  always @(negedge clk) begin
    #1.5;
    if (opnd_done_o) done_cnt++;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk); #0.5;
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 40 && pend; i++) step();
  endtask

  task automatic pop_one(input string rq);
    logic [7:0] e;
    for (int i = 0; i < 60 && !head_valid_o; i++) step();
    e = (exp_q.size() > 0) ? exp_q[0] : 8'h00;
    chk(head_valid_o && exp_q.size() > 0 && head_data_o == e, rq, {24'h0, head_data_o}, {24'h0, e});
    if (exp_q.size() > 0) void'(exp_q.pop_front());
    pop_i = 1'b1; step(); pop_i = 1'b0;
  endtask

  task automatic do_opnd(input bit wide, input bit drop_idle);
    int d0;
    d0 = done_cnt;
    opnd_req_i = 1'b1; opnd_wide_i = wide; bus_idle_i = 1'b1;
    for (int i = 0; i < 80 && done_cnt == d0; i++) begin
      step();
      if (drop_idle && ev_q.size() > 0) bus_idle_i = 1'b0;
    end
    opnd_req_i = 1'b0; opnd_wide_i = 1'b0; bus_idle_i = 1'b1;
  endtask

  task automatic do_flush(input logic [19:0] a);
    flush_i = 1'b1; flush_addr_i = a;
    if (pend && pend_fetch) drop = 1;
    exp_q.delete();
    step();
    flush_i = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, d0;
    logic [7:0] e;
    step(); step(); step();
    rst_ni = 1'b1;
    // R1 reset state
    chk(count_o == 0, "R1 count", count_o, 0);
    chk(!head_valid_o, "R1 head_valid", head_valid_o, 0);
    chk(!fetch_req_o, "R1 no fetch with busy bus", fetch_req_o, 0);
    chk(fetch_addr_o == RST_A, "R1 fetch_addr", fetch_addr_o, RST_A);
    step();

    // fill until full: R3 and R5
    bus_idle_i = 1'b1;
    for (int i = 0; i < 60 && count_o != 3'd4; i++) step();
    chk(count_o == 3'd4, "R3 fills to depth", count_o, 4);
    chk(fetch_addr_o == RST_A + 20'd4, "R5 addr after four bytes", fetch_addr_o, RST_A + 20'd4);
    c = 0;
    for (int i = 0; i < 8; i++) begin step(); if (fetch_req_o) c++; end
    chk(c == 0 && count_o == 3'd4, "R3 no fetch while full", c, 0);

    // R3 one free slot restarts prefetch
    pop_one("R4 first byte");
    chk(fetch_req_o && count_o == 3'd3, "R3 single slot refetch", {count_o, fetch_req_o}, {3'd3, 1'b1});

    // R4 ordering under a running stream
    for (int i = 0; i < 6; i++) pop_one("R4 order");

    // R6 operand wins at launch
    bus_idle_i = 1'b0; wait_quiet();
    pop_one("R4 before operand");
    ev_q.delete();
    do_opnd(1'b0, 1'b0);
    chk(ev_q.size() > 0 && ev_q[0] == 1, "R6 operand first", ev_q.size() > 0 ? ev_q[0] : -1, 1);

    // R8 wide operand as two byte cycles
    bus_idle_i = 1'b0; wait_quiet(); ev_q.delete();
    d0 = done_cnt;
    do_opnd(1'b1, 1'b1);
    chk(ev_q.size() >= 2 && ev_q[0] == 1 && ev_q[1] == 2, "R8 low then high",
        ev_q.size() >= 2 ? ev_q[1] : -1, 2);
    chk(hi_start_cyc - lo_ack_cyc == 1, "R8 back to back", hi_start_cyc - lo_ack_cyc, 1);
    for (int i = 0; i < 6; i++) step();
    chk(done_cnt - d0 == 1, "R8 single done", done_cnt - d0, 1);

    // R7 fetch in flight completes first
    pop_one("R4 room"); pop_one("R4 room");
    lat = 3;
    for (int i = 0; i < 40 && !(pend && pend_fetch); i++) step();
    ev_q.delete();
    do_opnd(1'b0, 1'b0);
    chk(ev_q.size() > 0 && ev_q[0] == 1 && overlap == 0, "R7 operand after fetch", overlap, 0);

    // R9 flush with a fetch in flight
    for (int i = 0; i < 40 && !(pend && pend_fetch); i++) step();
    do_flush(20'h01230);
    chk(count_o == 0 && !head_valid_o, "R9 queue emptied", count_o, 0);
    chk(fetch_addr_o == 20'h01230, "R9 address reloaded", fetch_addr_o, 20'h01230);
    for (int i = 0; i < 80 && count_o < 3'd2; i++) step();
    chk(fetch_addr_o == 20'h01232, "R5 addr after two new bytes", fetch_addr_o, 20'h01232);
    e = pat(20'h01230);
    chk(exp_q.size() > 0 && exp_q[0] == e, "R9 stale byte dropped", exp_q.size() > 0 ? exp_q[0] : 0, e);
    pop_one("R9 first target byte");
    pop_one("R9 second target byte");

    // R10 pop coinciding with a push
    lat = 2;
    for (int i = 0; i < 80 && !(pend && pend_fetch && wcnt == 0 && head_valid_o && count_o < 3'd4); i++) step();
    c = count_o;
    e = (exp_q.size() > 0) ? exp_q[0] : 8'h00;
    chk(head_valid_o && head_data_o == e, "R4 head at push-pop", head_data_o, e);
    if (exp_q.size() > 0) void'(exp_q.pop_front());
    pop_i = 1'b1; step(); pop_i = 1'b0;
    chk(count_o == c, "R10 count held", count_o, c);

    // R11 pop on empty ignored
    bus_idle_i = 1'b0; wait_quiet();
    do_flush(20'h00400);
    pop_i = 1'b1; step(); pop_i = 1'b0;
    chk(count_o == 0 && !head_valid_o, "R11 empty pop", count_o, 0);
    bus_idle_i = 1'b1;
    pop_one("R11 stream intact");
    pop_one("R11 stream intact");

    for (int i = 0; i < 10; i++) step();
    chk(dup == 0, "R2 one cycle outstanding", dup, 0);
    chk(prio_bad == 0, "R6 no fetch under operand", prio_bad, 0);
    chk(full_bad == 0, "R3 no fetch when full", full_bad, 0);
    chk(overlap == 0, "R7 no overlap", overlap, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule